// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One down-counting channel of a legacy-style interval timer. The channel counts on a single-cycle tick enable, not on a clock of its own. A gate input can suspend counting or restart it, depending on the mode. A count-load strobe writes a new start value and, in the same cycle, the counting mode. The channel then produces a live count value and a single output line, OUT. The shape of OUT over time is set by the mode: a level that rises at terminal count, a retriggerable one-shot, a periodic one-tick low pulse, a square wave, or a single strobe.

The host bus logic lives outside this block. It drives the load strobe, the load value and the mode, and it reads `count_o` whenever it needs to. Counting is binary only. A load value of zero stands for the full range of the counter, 2^W ticks.

Top module: `tick_counter_channel`

## Requirements
- R1: A load value of zero acts as a terminal count of 2^W. In mode 2, loading zero gives a period of 65536 ticks at W=16: the count wraps to 0xFFFF after the first tick, reaches 1 after 65535 ticks, and holds 0 again after 65536 ticks.
- R2: A load strobe restarts counting from the loaded value one clock later. Load takes priority over a gate restart and over a tick in the same cycle. At load, `load_mode` (3 bits) is captured. In modes 3 and 7 the count starts at the value with bit 0 cleared. OUT starts low in modes 0 and 1. In modes 2 and 6, OUT starts high unless the value is 1. In all other modes OUT starts high.
- R3: In modes 0, 1, 4 and 5 each counting tick lowers the count by one. From 0 the count wraps to 0xFFFF with no reload.
- R4: In mode 0, OUT goes high on the tick that brings the count to 0. It then stays high, through wraps, until the next load.
- R5: In mode 2, OUT is low exactly while the count equals 1. On the tick that follows, the count reloads from the loaded value and OUT returns high.
- R6: In mode 3 each tick lowers the count by two. A tick taken at count 2 reloads the even start value and toggles OUT. OUT is high for the first half-period after a load and low for the second.
- R7: In modes 1, 2, 3 and 5, a rising edge of `gate_in` restarts the count from the start value. OUT is then set low in mode 1 and high in the other three modes.
- R8: In modes 0, 2, 3 and 4 a low `gate_in` suspends counting. In mode 0, a rising gate edge does not restart the count. Modes 1 and 5 ignore the gate level.
- R9: In modes 4 and 5, OUT is low for exactly one tick, on the tick that first brings the count to 0 after a load or restart. Later wraps produce no pulse.
- R10: In mode 1, OUT goes low at load or retrigger and goes high when the count reaches 0. It then stays high until the next trigger.
- R11: Mode values 6 and 7 behave as modes 2 and 3.
- R12: With `tick_en` low, the count and OUT do not change. The exceptions are a load strobe and a gate restart.
- R13: After reset the channel is in mode 0 with count 0 and OUT low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count tick enable, one cycle per counter tick |
| gate_in | input | 1 | Gate: enables counting or triggers a restart, by mode |
| load_stb | input | 1 | Load strobe for the start value and the mode |
| load_val | input | W | Start value; 0 means 2^W |
| load_mode | input | 3 | Counting mode captured at load |
| count_o | output | W | Live count value |
| out_o | output | 1 | Channel output line |

## Verification
The bench uses the default width W=16. This makes the full-range case of a zero load reachable within the run: its 65536-tick period is walked tick by tick. Every wrap from 0 to 0xFFFF matches the true 16-bit boundary. Random loads use mostly small values, so terminal counts, reloads, square-wave toggles and strobe pulses occur thousands of times. Each cycle is compared against a reference model, for all eight mode codes and for mixed gate edges.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [2:0] {
        K_INT_TC    = 3'd0,
        K_ONESHOT   = 3'd1,
        K_RATE      = 3'd2,
        K_SQUARE    = 3'd3,
        K_SW_STROBE = 3'd4,
        K_HW_STROBE = 3'd5
    } kind_e;

    // Gate level gates the tick in these kinds (R8)
    function automatic logic gate_enables(kind_e k);
        return (k == K_INT_TC) || (k == K_RATE) ||
               (k == K_SQUARE) || (k == K_SW_STROBE);
    endfunction

    // Gate rising edge restarts the count in these kinds (R7)
    function automatic logic gate_retriggers(kind_e k);
        return (k == K_ONESHOT) || (k == K_RATE) ||
               (k == K_SQUARE) || (k == K_HW_STROBE);
    endfunction

    // OUT level at load or restart (R2, R7)
    function automatic logic start_out(kind_e k, logic value_is_one);
        case (k)
            K_INT_TC, K_ONESHOT: return 1'b0;
            K_RATE:              return ~value_is_one;
            default:             return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tcc_mode_decode.sv
module tcc_mode_decode
    import tcc_pkg::*;
(
    input  logic [2:0] mode_raw,
    output kind_e      kind
);
    // R11: codes 6 and 7 alias the periodic kinds
    always_comb begin
        case (mode_raw)
            3'd6:    kind = K_RATE;
            3'd7:    kind = K_SQUARE;
            default: kind = kind_e'(mode_raw);
        endcase
    end
endmodule

// File: rtl/tcc_gate_edge.sv
module tcc_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic rise
);
    logic gate_d, gate_q;

    always_comb gate_d = gate;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end

    assign rise = gate & ~gate_q;
endmodule

// File: rtl/tcc_count_steps.sv
module tcc_count_steps #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] init,
    output logic [W-1:0] dec1,
    output logic [W-1:0] dec2,
    output logic [W-1:0] even_start,
    output logic         at_one,
    output logic         at_two
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    always_comb begin
        dec1       = cnt - ONE;
        dec2       = cnt - TWO;
        even_start = {init[W-1:1], 1'b0};
        at_one     = (cnt == ONE);
        at_two     = (cnt == TWO);
    end
endmodule

// File: rtl/tick_counter_channel.sv
module tick_counter_channel
    import tcc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         gate_in,
    input  logic         load_stb,
    input  logic [W-1:0] load_val,
    input  logic [2:0]   load_mode,
    output logic [W-1:0] count_o,
    output logic         out_o
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] init;
        kind_e        kind;
        logic         out;
        logic         done;
    } state_t;

    state_t st_d, st_q;

    kind_e        ld_kind;
    logic         gate_rise;
    logic [W-1:0] dec1, dec2, even_start;
    logic         at_one, at_two;
    logic         count_en, restart;

    tcc_mode_decode u_dec (
        .mode_raw (load_mode),
        .kind     (ld_kind)
    );

    tcc_gate_edge u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (gate_in),
        .rise  (gate_rise)
    );

    tcc_count_steps #(.W(W)) u_steps (
        .cnt        (st_q.cnt),
        .init       (st_q.init),
        .dec1       (dec1),
        .dec2       (dec2),
        .even_start (even_start),
        .at_one     (at_one),
        .at_two     (at_two)
    );

    always_comb begin
        st_d     = st_q;
        count_en = tick_en & (gate_in | ~gate_enables(st_q.kind));
        restart  = gate_rise & gate_retriggers(st_q.kind);

        if (load_stb) begin
            // R2: load wins over restart and tick
            st_d.kind = ld_kind;
            st_d.init = load_val;
            st_d.cnt  = (ld_kind == K_SQUARE) ? {load_val[W-1:1], 1'b0} : load_val;
            st_d.out  = start_out(ld_kind, load_val == ONE);
            st_d.done = 1'b0;
        end else if (restart) begin
            // R7
            st_d.cnt  = (st_q.kind == K_SQUARE) ? even_start : st_q.init;
            st_d.out  = start_out(st_q.kind, st_q.init == ONE);
            st_d.done = 1'b0;
        end else if (count_en) begin
            case (st_q.kind)
                K_INT_TC, K_ONESHOT: begin
                    // R3 wrap, R4 / R10 sticky rise at zero
                    st_d.cnt = dec1;
                    if (at_one) st_d.out = 1'b1;
                end
                K_RATE: begin
                    // R5
                    st_d.cnt = at_one ? st_q.init : dec1;
                    st_d.out = ~(st_d.cnt == ONE);
                end
                K_SQUARE: begin
                    // R6
                    if (at_two) begin
                        st_d.cnt = even_start;
                        st_d.out = ~st_q.out;
                    end else begin
                        st_d.cnt = dec2;
                    end
                end
                default: begin
                    // R9: strobe kinds
                    st_d.cnt = dec1;
                    if (at_one && !st_q.done) begin
                        st_d.out  = 1'b0;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.out = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            // R13
            st_q.cnt  <= '0;
            st_q.init <= '0;
            st_q.kind <= K_INT_TC;
            st_q.out  <= 1'b0;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign out_o   = st_q.out;
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_en,
    input logic         gate_in,
    input logic         load_stb,
    input logic [W-1:0] load_val,
    input logic [2:0]   load_mode,
    input logic [W-1:0] count_o,
    input logic         out_o,
    input logic [2:0]   kind_q
);
    p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && load_mode[1:0] != 2'b11) |=> count_o == $past(load_val));

    p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load_stb && !gate_in) |=> ($stable(count_o) && $stable(out_o)));

    p_rate_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == 3'd2) |-> (out_o == (count_o != W'(1))));

    p_square_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == 3'd3) |-> !count_o[0]);

    p_sticky_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == 3'd0 && out_o && !load_stb) |=> out_o);

    p_strobe_one_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind_q == 3'd4 || kind_q == 3'd5) && !out_o && tick_en && gate_in && !load_stb)
        |=> out_o);
endmodule

bind tick_counter_channel tcc_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .gate_in   (gate_in),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .load_mode (load_mode),
    .count_o   (count_o),
    .out_o     (out_o),
    .kind_q    (st_q.kind)
);

// File: tb/tick_counter_channel_tb_top.sv
module tick_counter_channel_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         gate_in = 1'b0;
    logic         load_stb = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [2:0]   load_mode = 3'd0;
    logic [W-1:0] count_o;
    logic         out_o;

    int errors = 0;
    int checks = 0;

    // Reference model state
    int unsigned m_cnt = 0, m_init = 0, m_kind = 0;
    bit m_out = 0, m_done = 0, m_gprev = 0;

    always #2 clk = ~clk;

    tick_counter_channel #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_in(gate_in),
        .load_stb(load_stb), .load_val(load_val), .load_mode(load_mode),
        .count_o(count_o), .out_o(out_o)
    );

    function automatic int unsigned kind_of(int unsigned m);
        return (m == 6) ? 2 : (m == 7) ? 3 : m;
    endfunction

    function automatic bit first_out(int unsigned k, int unsigned v);
        if (k <= 1) return 1'b0;
        if (k == 2) return (v != 1);
        return 1'b1;
    endfunction

    function automatic string req_of(int unsigned k);
        case (k)
            0: return "R4";
            1: return "R10";
            2: return "R5";
            3: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic model_step();
        bit rise;
        bit trig;
        rise = gate_in && !m_gprev;
        m_gprev = gate_in;
        trig = rise && (m_kind == 1 || m_kind == 2 || m_kind == 3 || m_kind == 5);
        if (load_stb) begin
            m_kind = kind_of(load_mode);
            m_init = load_val;
            m_cnt  = (m_kind == 3) ? (load_val & 16'hFFFE) : load_val;
            m_out  = first_out(m_kind, load_val);
            m_done = 0;
        end else if (trig) begin
            m_cnt  = (m_kind == 3) ? (m_init & 16'hFFFE) : m_init;
            m_out  = first_out(m_kind, m_init);
            m_done = 0;
        end else if (tick_en && (gate_in || m_kind == 1 || m_kind == 5)) begin
            case (m_kind)
                0, 1: begin
                    if (m_cnt == 1) m_out = 1;
                    m_cnt = (m_cnt + 65535) % 65536;
                end
                2: begin
                    m_cnt = (m_cnt == 1) ? m_init : (m_cnt + 65535) % 65536;
                    m_out = (m_cnt != 1);
                end
                3: begin
                    if (m_cnt == 2) begin
                        m_cnt = m_init & 16'hFFFE;
                        m_out = !m_out;
                    end else begin
                        m_cnt = (m_cnt + 65534) % 65536;
                    end
                end
                default: begin
                    if (m_cnt == 1 && !m_done) begin
                        m_out = 0;
                        m_done = 1;
                    end else begin
                        m_out = 1;
                    end
                    m_cnt = (m_cnt + 65535) % 65536;
                end
            endcase
        end
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic drive(bit ld, int unsigned v, int unsigned m, bit t, bit g);
        load_stb = ld; load_val = W'(v); load_mode = 3'(m); tick_en = t; gate_in = g;
    endtask

    task automatic expect_state(string req, int c, int o);
        chk(req, int'(count_o), c);
        chk(req, int'(out_o), o);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_state("R13", 0, 0);

        // Mode 0 (R2, R4, R3)
        drive(1, 5, 0, 0, 1); cyc(); expect_state("R2", 5, 0);
        drive(0, 0, 0, 1, 1);
        repeat (4) cyc();
        expect_state("R4", 1, 0);
        cyc(); expect_state("R4", 0, 1);
        cyc(); expect_state("R3", 16'hFFFF, 1);
        // Gate level suspends, rise no restart (R8)
        drive(0, 0, 0, 1, 0); repeat (2) cyc(); expect_state("R8", 16'hFFFF, 1);
        drive(0, 0, 0, 1, 1); cyc(); expect_state("R8", 16'hFFFE, 1);
        // No tick (R12)
        drive(0, 0, 0, 0, 1); repeat (3) cyc(); expect_state("R12", 16'hFFFE, 1);

        // Mode 2 (R5)
        drive(1, 3, 2, 0, 1); cyc(); expect_state("R2", 3, 1);
        drive(0, 0, 0, 1, 1); cyc(); expect_state("R5", 2, 1);
        cyc(); expect_state("R5", 1, 0);
        cyc(); expect_state("R5", 3, 1);
        cyc(); expect_state("R5", 2, 1);
        drive(0, 0, 0, 1, 0); cyc(); expect_state("R8", 2, 1);
        drive(0, 0, 0, 1, 1); cyc(); expect_state("R7", 3, 1);

        // Mode 3 (R6)
        drive(1, 7, 3, 0, 1); cyc(); expect_state("R6", 6, 1);
        drive(0, 0, 0, 1, 1);
        cyc(); expect_state("R6", 4, 1);
        cyc(); expect_state("R6", 2, 1);
        cyc(); expect_state("R6", 6, 0);
        repeat (3) cyc(); expect_state("R6", 6, 1);

        // Aliases (R11)
        drive(1, 2, 6, 0, 1); cyc(); expect_state("R11", 2, 1);
        drive(0, 0, 0, 1, 1); cyc(); expect_state("R11", 1, 0);
        cyc(); expect_state("R11", 2, 1);
        drive(1, 5, 7, 0, 1); cyc(); expect_state("R11", 4, 1);
        drive(0, 0, 0, 1, 1); cyc(); cyc(); expect_state("R11", 4, 0);

        // Mode 1 (R10, R7)
        drive(1, 4, 1, 0, 0); cyc(); expect_state("R10", 4, 0);
        drive(0, 0, 0, 1, 0); repeat (3) cyc(); expect_state("R10", 1, 0);
        cyc(); expect_state("R10", 0, 1);
        cyc(); expect_state("R10", 16'hFFFF, 1);
        drive(0, 0, 0, 1, 1); cyc(); expect_state("R7", 4, 0);

        // Mode 4 (R9)
        drive(1, 2, 4, 0, 1); cyc(); expect_state("R9", 2, 1);
        drive(0, 0, 0, 1, 1); cyc(); expect_state("R9", 1, 1);
        cyc(); expect_state("R9", 0, 0);
        cyc(); expect_state("R9", 16'hFFFF, 1);
        drive(0, 0, 0, 1, 0); repeat (2) cyc(); expect_state("R8", 16'hFFFF, 1);

        // Mode 5 restart (R7)
        drive(1, 3, 5, 0, 0); cyc(); expect_state("R7", 3, 1);
        drive(0, 0, 0, 1, 0); cyc(); expect_state("R7", 2, 1);
        drive(0, 0, 0, 1, 1); cyc(); expect_state("R7", 3, 1);

        // Load mid-count wins over tick (R2)
        drive(1, 10, 2, 0, 1); cyc();
        drive(0, 0, 0, 1, 1); repeat (2) cyc(); expect_state("R2", 8, 1);
        drive(1, 20, 2, 1, 1); cyc(); expect_state("R2", 20, 1);

        // Zero load = 65536 (R1)
        drive(1, 0, 2, 0, 1); cyc(); expect_state("R1", 0, 1);
        drive(0, 0, 0, 1, 1); cyc(); expect_state("R1", 16'hFFFF, 1);
        repeat (65534) cyc(); expect_state("R1", 1, 0);
        cyc(); expect_state("R1", 0, 1);

        // Random phase against the model
        for (int i = 0; i < 30000; i++) begin
            bit ld;
            int unsigned v;
            ld = ($urandom % 40) == 0;
            v  = (($urandom % 8) == 0) ? ($urandom % 65536) : ($urandom % 12);
            drive(ld, v, $urandom % 8, ($urandom % 4) != 0,
                  (($urandom % 8) != 0) ? gate_in : !gate_in);
            cyc();
            chk(req_of(m_kind), int'(count_o), int'(m_cnt));
            chk(req_of(m_kind), int'(out_o), int'(m_out));
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule